// File: doc/BRIEF.md
# Multiplexed Bus Master Cycle Engine

This block turns a stream of word or byte transfer requests into read and write cycles on a shared 16-bit address/data bus with eight extra high address lines, which together give a 24-bit address. Before the first cycle it raises a bus request and waits for the grant. Each cycle then has two parts. In the address part, a strobe with selectable polarity marks the address. In the data part, a data strobe is active, and the slave stretches this part until it answers with its ready input.

The engine drives the transceiver direction lines and the byte-lane signals. Byte lanes can be signalled either as a two-bit mask or as a single byte flag plus address bit 0. Once the bus is granted, the engine keeps it for a burst of one transfer, of up to eight transfers, or of unlimited length. The burst ends early when the host asserts its release input. A request is handed over with a valid/ready pair. Completion is reported by a one-clock done pulse, which carries the read data when the transfer is a read.

Top module: `dmab_cycle_engine`

## Requirements
- R1: Clock 1 of a cycle is the first clock with `drv_en_o` high. A cycle then lasts exactly 6 clocks when `ready_i` is high in its 5th clock. Each extra clock in which `ready_i` is sampled low during that wait clock adds exactly one clock.
- R2: With the bus idle and `hlda_i` low, `hold_o` rises one clock after `req_valid_i` is first sampled. It stays high through the last clock of the final transfer of the tenure, and it falls in the following clock.
- R3: `drv_en_o` is high only while both `hold_o` and `hlda_i` are high. The first cycle's address phase starts the clock after `hlda_i` is sampled high.
- R4: In cycle clocks 1 and 2, `dal_o` carries address bits 15:0 and `addr_hi_o` carries bits 23:16. From clock 3 to the end of a write, `dal_o` carries the write data.
- R5: With `cfg_as_low_i`=0, `strobe_o` is high in clock 1 only. With `cfg_as_low_i`=1 it is the inverse, low in clock 1 only. `das_o` is high from clock 3 up to and including the wait clock in which ready is seen, and it is low in clocks 1, 2 and the final clock.
- R6: `dalo_o` is high in clocks 1 and 2 of a read and in every clock of a write. `dali_o` is high from clock 3 to the end of a read only. The two are never high together.
- R7: With `cfg_byte_sig_i`=0, `lane_o` equals the request's two-bit lane code for the whole cycle. The codes are 00 = whole word, 01 = upper byte (bits 15:8), 10 = lower byte (bits 7:0) and 11 = no byte.
- R8: With `cfg_byte_sig_i`=1, `lane_o[0]` is a byte flag, and `lane_o[1]` is 0. The flag is 1 for lane code 01 or 10 and 0 otherwise. For byte transfers, `dal_o[0]` in the address phase is 1 for the upper byte and 0 for the lower byte.
- R9: `cfg_burst_i` sets the burst length. A value of 0 allows one transfer per tenure. A value of 1 allows up to 8 transfers. A value of 2 (or 3) continues for as long as requests are waiting.
- R10: If `busrel_i` is high in any clock of a tenure, the tenure ends after the transfer then in progress completes.
- R11: For a read, `done_o` and `rd_data_o` present the `dal_i` value sampled in the clock where `ready_i` was seen.
- R12: `req_ready_o` pulses once per accepted request, in the clock before that request's address phase. `done_o` pulses once in each cycle's final clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_as_low_i | input | 1 | Address strobe form: 0 high-active, 1 low-active |
| cfg_byte_sig_i | input | 1 | Lane signalling: 0 two-bit mask, 1 byte flag plus DAL bit 0 |
| cfg_burst_i | input | 2 | Burst length: 0 one, 1 eight, 2/3 unlimited |
| req_valid_i | input | 1 | Transfer request present |
| req_ready_o | output | 1 | Request accepted this clock |
| req_wr_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | 24 | Transfer address |
| req_wdata_i | input | 16 | Write data |
| req_lanes_i | input | 2 | Lane code (00 word, 01 upper, 10 lower, 11 none) |
| done_o | output | 1 | Final clock of a cycle |
| rd_data_o | output | 16 | Read data, valid with done_o on reads |
| hold_o | output | 1 | Bus request |
| hlda_i | input | 1 | Bus grant |
| drv_en_o | output | 1 | Bus drivers enabled |
| strobe_o | output | 1 | Address strobe |
| das_o | output | 1 | Data strobe |
| read_o | output | 1 | Cycle is a read |
| dalo_o | output | 1 | Transceiver drives outward |
| dali_o | output | 1 | Transceiver drives inward |
| dal_o | output | 16 | Multiplexed address/data out |
| dal_i | input | 16 | Data in from bus |
| addr_hi_o | output | 8 | Address bits 23:16 |
| lane_o | output | 2 | Byte lane mask or byte flag |
| ready_i | input | 1 | Slave ready |
| busrel_i | input | 1 | Host asks to end the burst |

## Verification
The release input and the continuation decision can fall in the same clock. The engine chooses, in a cycle's final clock, whether to start another address phase, and that is the clock a release request has to override. The bench holds `busrel_i` high through the third transfer of an open burst, up to and including that transfer's final clock, while more requests are queued. It then judges the result by the count of transfers in each tenure, expecting three and then the rest. The burst limit is checked against a queue longer than the limit in the same way.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 16;
    localparam int HI_W    = ADDR_W - DATA_W;
    localparam int BURST_N = 8;

    typedef enum logic [2:0] {
        PH_IDLE, PH_REQ, PH_A1, PH_A2, PH_D1, PH_D2, PH_DW, PH_END
    } phase_t;

    typedef enum logic [1:0] {
        BL_ONE = 2'd0, BL_EIGHT = 2'd1, BL_OPEN = 2'd2, BL_OPEN2 = 2'd3
    } burst_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        lanes;
    } xfer_t;

    function automatic logic is_byte_lane(input logic [1:0] l);
        return (l == 2'b01) || (l == 2'b10);
    endfunction

    function automatic logic in_cycle(input phase_t p);
        return (p != PH_IDLE) && (p != PH_REQ);
    endfunction
endpackage

// File: rtl/dmab_seq.sv
module dmab_seq
    import dmab_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_valid_i,
    input  xfer_t             req_i,
    input  logic              hlda_i,
    input  logic              ready_i,
    input  logic              stop_i,
    input  logic [DATA_W-1:0] dal_i,
    output phase_t            phase_o,
    output xfer_t             cur_o,
    output logic              accept_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);
    phase_t phase_q, phase_d;
    xfer_t  cur_q;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        phase_d  = phase_q;
        accept_o = 1'b0;
        case (phase_q)
            PH_IDLE: if (req_valid_i && !hlda_i) phase_d = PH_REQ;
            PH_REQ: begin
                if (hlda_i) begin
                    if (req_valid_i) begin
                        phase_d  = PH_A1;
                        accept_o = 1'b1;
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end
            end
            PH_A1: phase_d = PH_A2;
            PH_A2: phase_d = PH_D1;
            PH_D1: phase_d = PH_D2;
            PH_D2: phase_d = PH_DW;
            PH_DW: if (ready_i) phase_d = PH_END;
            PH_END: begin
                if (!stop_i && req_valid_i && hlda_i) begin
                    phase_d  = PH_A1;
                    accept_o = 1'b1;
                end else begin
                    phase_d = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_IDLE;
            cur_q   <= '0;
            rdata_q <= '0;
        end else begin
            phase_q <= phase_d;
            if (accept_o) cur_q <= req_i;
            if (phase_q == PH_DW && ready_i) rdata_q <= dal_i;
        end
    end

    assign phase_o = phase_q;
    assign cur_o   = cur_q;
    assign done_o  = (phase_q == PH_END);
    assign rdata_o = rdata_q;
endmodule

// File: rtl/dmab_burst.sv
module dmab_burst
    import dmab_pkg::*;
#(
    parameter int LEN_N = BURST_N
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tenure_i,
    input  logic       accept_i,
    input  logic [1:0] mode_i,
    input  logic       busrel_i,
    output logic       stop_o
);
    localparam int CNT_W = $clog2(LEN_N + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LEN_N);

    logic [CNT_W-1:0] cnt_q;
    logic             rel_q;
    logic             limit;

    always_ff @(posedge clk_i) begin
        if (rst_i || !tenure_i) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else begin
            if (accept_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (busrel_i) rel_q <= 1'b1;
        end
    end

    always_comb begin
        case (burst_t'(mode_i))
            BL_ONE:   limit = (cnt_q != '0);
            BL_EIGHT: limit = (cnt_q >= CNT_MAX);
            default:  limit = 1'b0;
        endcase
    end

    assign stop_o = limit || rel_q || busrel_i;
endmodule

// File: rtl/dmab_pins.sv
module dmab_pins
    import dmab_pkg::*;
(
    input  phase_t            phase_i,
    input  xfer_t             cur_i,
    input  logic              as_low_i,
    input  logic              byte_sig_i,
    output logic              hold_o,
    output logic              drv_en_o,
    output logic              strobe_o,
    output logic              das_o,
    output logic              read_o,
    output logic              dalo_o,
    output logic              dali_o,
    output logic [DATA_W-1:0] dal_o,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic [1:0]        lane_o
);
    logic cyc, addr_ph, data_ph, bsel;

    assign cyc     = in_cycle(phase_i);
    assign addr_ph = (phase_i == PH_A1) || (phase_i == PH_A2);
    assign data_ph = cyc && !addr_ph;
    assign bsel    = byte_sig_i && is_byte_lane(cur_i.lanes);

    assign hold_o   = (phase_i != PH_IDLE);
    assign drv_en_o = cyc;
    assign strobe_o = (phase_i == PH_A1) ^ as_low_i;
    assign das_o    = (phase_i == PH_D1) || (phase_i == PH_D2) || (phase_i == PH_DW);
    assign read_o   = cyc && !cur_i.wr;
    assign dalo_o   = cyc && (cur_i.wr || addr_ph);
    assign dali_o   = data_ph && !cur_i.wr;

    always_comb begin
        dal_o = '0;
        if (addr_ph) begin
            dal_o = cur_i.addr[DATA_W-1:0];
            if (bsel) dal_o[0] = (cur_i.lanes == 2'b01);
        end else if (data_ph && cur_i.wr) begin
            dal_o = cur_i.wdata;
        end
    end

    assign addr_hi_o = cyc ? cur_i.addr[ADDR_W-1:DATA_W] : '0;

    always_comb begin
        if (!cyc)            lane_o = 2'b00;
        else if (byte_sig_i) lane_o = {1'b0, is_byte_lane(cur_i.lanes)};
        else                 lane_o = cur_i.lanes;
    end
endmodule

// File: rtl/dmab_cycle_engine.sv
module dmab_cycle_engine
    import dmab_pkg::*;
#(
    parameter int LEN_N = BURST_N
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cfg_as_low_i,
    input  logic              cfg_byte_sig_i,
    input  logic [1:0]        cfg_burst_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [1:0]        req_lanes_i,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              hold_o,
    input  logic              hlda_i,
    output logic              drv_en_o,
    output logic              strobe_o,
    output logic              das_o,
    output logic              read_o,
    output logic              dalo_o,
    output logic              dali_o,
    output logic [DATA_W-1:0] dal_o,
    input  logic [DATA_W-1:0] dal_i,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic [1:0]        lane_o,
    input  logic              ready_i,
    input  logic              busrel_i
);
    phase_t phase;
    xfer_t  req, cur;
    logic   stop, accept;

    assign req = '{wr: req_wr_i, addr: req_addr_i, wdata: req_wdata_i, lanes: req_lanes_i};

    dmab_seq u_seq (
        .clk_i(clk_i), .rst_i(rst_i), .req_valid_i(req_valid_i), .req_i(req),
        .hlda_i(hlda_i), .ready_i(ready_i), .stop_i(stop), .dal_i(dal_i),
        .phase_o(phase), .cur_o(cur), .accept_o(accept), .done_o(done_o),
        .rdata_o(rd_data_o)
    );

    dmab_burst #(.LEN_N(LEN_N)) u_burst (
        .clk_i(clk_i), .rst_i(rst_i), .tenure_i(phase != PH_IDLE),
        .accept_i(accept), .mode_i(cfg_burst_i), .busrel_i(busrel_i),
        .stop_o(stop)
    );

    dmab_pins u_pins (
        .phase_i(phase), .cur_i(cur), .as_low_i(cfg_as_low_i),
        .byte_sig_i(cfg_byte_sig_i), .hold_o(hold_o), .drv_en_o(drv_en_o),
        .strobe_o(strobe_o), .das_o(das_o), .read_o(read_o), .dalo_o(dalo_o),
        .dali_o(dali_o), .dal_o(dal_o), .addr_hi_o(addr_hi_o), .lane_o(lane_o)
    );

    assign req_ready_o = accept;
endmodule

// File: rtl/dmab_chk.sv
module dmab_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       hold_o,
    input logic       hlda_i,
    input logic       drv_en_o,
    input logic       strobe_o,
    input logic       das_o,
    input logic       dalo_o,
    input logic       dali_o,
    input logic       done_o,
    input logic       req_ready_o,
    input logic       cfg_as_low_i,
    input logic [1:0] cfg_burst_i
);
    logic [7:0] len_q;
    logic [7:0] ten_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            len_q <= '0;
            ten_q <= '0;
        end else begin
            if (req_ready_o)                      len_q <= '0;
            else if (drv_en_o && len_q != 8'hFF)  len_q <= len_q + 1'b1;
            if (!hold_o)                          ten_q <= '0;
            else if (req_ready_o && ten_q != 8'hFF) ten_q <= ten_q + 1'b1;
        end
    end

    AST_MIN_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> len_q >= 8'd5); // R1
    AST_HOLD_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(hold_o) |-> $past(done_o)); // R2
    AST_DRV_GRANTED: assert property (@(posedge clk_i) disable iff (rst_i)
        drv_en_o |-> (hold_o && hlda_i)); // R3
    AST_DAS_APART: assert property (@(posedge clk_i) disable iff (rst_i)
        das_o |-> (strobe_o == cfg_as_low_i)); // R5
    AST_DIR_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(dalo_o && dali_o)); // R6
    AST_BURST_CAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (hold_o && cfg_burst_i == 2'd1) |-> ten_q <= 8'd8); // R9
    AST_SINGLE_CAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (hold_o && cfg_burst_i == 2'd0) |-> ten_q <= 8'd1); // R9
endmodule

bind dmab_cycle_engine dmab_chk u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .hold_o(hold_o), .hlda_i(hlda_i),
    .drv_en_o(drv_en_o), .strobe_o(strobe_o), .das_o(das_o), .dalo_o(dalo_o),
    .dali_o(dali_o), .done_o(done_o), .req_ready_o(req_ready_o),
    .cfg_as_low_i(cfg_as_low_i), .cfg_burst_i(cfg_burst_i)
);

// File: tb/dmab_cycle_engine_bench.sv
`timescale 1ns/1ps
module dmab_cycle_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        as_low = 1'b0, byte_sig = 1'b0;
    logic [1:0]  burst = 2'd0;
    logic        req_valid = 1'b0, req_wr = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        req_ready, done, hold, hlda = 1'b0, drv_en, strobe, das, rd;
    logic        dalo, dali, ready = 1'b0, busrel = 1'b0;
    logic [15:0] rd_data, dal_out, dal_in = '0;
    logic [7:0]  addr_hi;
    logic [1:0]  lane;

    always #2.5 clk = ~clk;

    dmab_cycle_engine u_dmab_cycle_engine (
        .clk_i(clk), .rst_i(rst), .cfg_as_low_i(as_low), .cfg_byte_sig_i(byte_sig),
        .cfg_burst_i(burst), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_wr_i(req_wr), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .req_lanes_i(req_lanes), .done_o(done), .rd_data_o(rd_data), .hold_o(hold),
        .hlda_i(hlda), .drv_en_o(drv_en), .strobe_o(strobe), .das_o(das), .read_o(rd),
        .dalo_o(dalo), .dali_o(dali), .dal_o(dal_out), .dal_i(dal_in),
        .addr_hi_o(addr_hi), .lane_o(lane), .ready_i(ready), .busrel_i(busrel)
    );

    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // slave model, driven just after each rising edge
    int cur_waits = 0, das_seen = 0, rel_at = -1;
    int done_cnt = 0;
    always @(posedge clk) begin
        #1;
        hlda = hold;
        if (das) das_seen++; else das_seen = 0;
        ready = das && (das_seen >= 3 + cur_waits);
        busrel = (rel_at >= 0) && (done_cnt == rel_at);
    end

    // monitor, sampled at the falling edge
    bit in_cyc = 0, hold_prev = 0, grant_bad = 0;
    int len = 0, fin_len = 0, acc_cnt = 0, ten_cnt = 0, ten_x = 0;
    int ten_log [0:31];
    logic a_strobe, b_strobe, a_das, a_dalo, a_dali, d_das, d_dalo, d_dali, fin_das;
    logic [15:0] a_dal, d_dal, fin_rdata;
    logic [7:0]  a_hi;
    logic [1:0]  a_lane;
    always @(negedge clk) begin
        if (!rst) begin
            if (drv_en && !(hold && hlda)) grant_bad = 1;
            if (req_ready) acc_cnt++;
            if (hold && !hold_prev) ten_x = 0;
            if (drv_en && !in_cyc) begin
                in_cyc = 1; len = 1;
                a_strobe = strobe; a_dal = dal_out; a_hi = addr_hi; a_lane = lane;
                a_dalo = dalo; a_dali = dali; a_das = das;
            end else if (in_cyc) begin
                len++;
                if (len == 2) b_strobe = strobe;
                if (len == 3) begin d_das = das; d_dalo = dalo; d_dali = dali; d_dal = dal_out; end
            end
            if (done) begin
                in_cyc = 0; fin_len = len; fin_das = das; fin_rdata = rd_data;
                done_cnt++; ten_x++;
            end
            if (!hold && hold_prev) begin
                if (ten_cnt < 32) ten_log[ten_cnt] = ten_x;
                ten_cnt++;
            end
            hold_prev = hold;
        end
    end

    // {wr, addr, wdata, rdata, lanes, as_low, byte_sig, waits}
    localparam int VW = 65;
    localparam logic [VW-1:0] VECS [0:5] = '{
        {1'b0, 24'h123456, 16'h0000, 16'hBEEF, 2'b00, 1'b0, 1'b0, 4'd0},
        {1'b1, 24'hA50F00, 16'h1234, 16'h0000, 2'b01, 1'b1, 1'b0, 4'd2},
        {1'b0, 24'hFFFFFE, 16'h0000, 16'h0001, 2'b10, 1'b0, 1'b0, 4'd5},
        {1'b1, 24'h000002, 16'hFFFF, 16'h0000, 2'b11, 1'b1, 1'b0, 4'd1},
        {1'b1, 24'h3C0010, 16'h55AA, 16'h0000, 2'b01, 1'b0, 1'b1, 4'd0},
        {1'b0, 24'h7E8021, 16'h0000, 16'h8001, 2'b10, 1'b1, 1'b1, 4'd3}
    };

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 3) begin
            @(negedge clk);
            if (!hold && !hlda) quiet++; else quiet = 0;
        end
    endtask

    task automatic send_queue(input int n, input bit wr);
        for (int k = 0; k < n; k++) begin
            req_wr = wr; req_addr = 24'h010000 + 24'(k * 2); req_wdata = 16'(k);
            req_lanes = 2'b00; req_valid = 1'b1;
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            @(posedge clk); #2;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // reset state
        check(!hold && !drv_en && !das && !dalo && !dali && !done && !req_ready,
              "R2 reset idle outputs", {hold, drv_en, das, dalo, dali}, 0);

        // table walk: one transfer per vector, single-transfer bursts
        for (int i = 0; i < 6; i++) begin
            logic [VW-1:0] v;
            logic [15:0] exp_dal;
            logic [1:0]  exp_lane;
            int base, tbase;
            v = VECS[i];
            req_wr = v[64]; req_addr = v[63:40]; req_wdata = v[39:24]; dal_in = v[23:8];
            req_lanes = v[7:6]; as_low = v[5]; byte_sig = v[4]; cur_waits = int'(v[3:0]);
            burst = 2'd0;
            base = done_cnt; tbase = ten_cnt;
            @(posedge clk); #2;
            req_valid = 1'b1;
            @(negedge clk);
            @(negedge clk);
            check(hold === 1'b1, "R2 hold one clock after request", hold, 1);
            while (!req_ready) @(negedge clk);
            @(posedge clk); #2; req_valid = 1'b0;
            while (done_cnt == base) @(negedge clk);
            wait_idle();
            exp_dal = req_addr[15:0];
            if (byte_sig && req_lanes == 2'b01) exp_dal[0] = 1'b1;
            if (byte_sig && req_lanes == 2'b10) exp_dal[0] = 1'b0;
            exp_lane = byte_sig ? {1'b0, (req_lanes == 2'b01 || req_lanes == 2'b10)} : req_lanes;
            check(fin_len == 6 + cur_waits, "R1 cycle length", fin_len, 6 + cur_waits);
            check(a_hi == req_addr[23:16], "R4 high address", a_hi, req_addr[23:16]);
            check(a_dal == exp_dal, "R4/R8 address on dal", a_dal, exp_dal);
            check(a_strobe == !as_low && b_strobe == as_low, "R5 strobe form",
                  {a_strobe, b_strobe}, {!as_low, as_low});
            check(!a_das && d_das && !fin_das, "R5 das window", {a_das, d_das, fin_das}, 3'b010);
            check(a_dalo && !a_dali && d_dalo == req_wr && d_dali == !req_wr, "R6 direction",
                  {a_dalo, a_dali, d_dalo, d_dali}, {1'b1, 1'b0, req_wr, !req_wr});
            check(a_lane == exp_lane, byte_sig ? "R8 byte flag" : "R7 lane mask", a_lane, exp_lane);
            if (req_wr) check(d_dal == req_wdata, "R4 write data", d_dal, req_wdata);
            else        check(fin_rdata == dal_in, "R11 read data", fin_rdata, dal_in);
            check(ten_cnt == tbase + 1 && ten_log[tbase] == 1, "R2 one tenure", ten_log[tbase], 1);
        end
        check(!grant_bad, "R3 drivers only under grant", grant_bad, 0);
        check(acc_cnt == done_cnt, "R12 accept vs done pulses", acc_cnt, done_cnt);

        // burst of eight with ten queued
        as_low = 0; byte_sig = 0; cur_waits = 0; dal_in = 16'h0;
        begin
            int tb0;
            tb0 = ten_cnt; burst = 2'd1;
            send_queue(10, 1'b0);
            wait_idle();
            check(ten_cnt == tb0 + 2, "R9 eight-burst tenures", ten_cnt - tb0, 2);
            check(ten_log[tb0] == 8, "R9 eight-burst first tenure", ten_log[tb0], 8);
            check(ten_log[tb0 + 1] == 2, "R9 eight-burst remainder", ten_log[tb0 + 1], 2);
        end
        // unlimited burst
        begin
            int tb0;
            tb0 = ten_cnt; burst = 2'd2;
            send_queue(10, 1'b1);
            wait_idle();
            check(ten_cnt == tb0 + 1 && ten_log[tb0] == 10, "R9 open burst", ten_log[tb0], 10);
        end
        // single mode with a queue
        begin
            int tb0;
            tb0 = ten_cnt; burst = 2'd0;
            send_queue(3, 1'b0);
            wait_idle();
            check(ten_cnt == tb0 + 3, "R9 single mode tenures", ten_cnt - tb0, 3);
        end
        // release during the third transfer of an open burst
        begin
            int tb0;
            tb0 = ten_cnt; burst = 2'd2;
            rel_at = done_cnt + 2;
            send_queue(6, 1'b1);
            wait_idle();
            rel_at = -1;
            check(ten_log[tb0] == 3, "R10 release ends burst", ten_log[tb0], 3);
            check(ten_cnt == tb0 + 2 && ten_log[tb0 + 1] == 3, "R10 rest in next tenure",
                  ten_log[tb0 + 1], 3);
        end
        check(!grant_bad, "R3 drivers only under grant (bursts)", grant_bad, 0);
        check(acc_cnt == done_cnt, "R12 accept vs done pulses (bursts)", acc_cnt, done_cnt);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule